// File: doc/BRIEF.md
# Graphics RAM Block-Write Datapath

This block is a small synthesizable model of a graphics DRAM array with its write-side command front end. A command bus carries bank activate, write and special register-load commands, each qualified by a special-function strobe. Normal writes update one column word and are filtered by a per-byte data mask and, when the bank has it turned on, by a per-bit write mask. Block writes fill eight aligned neighbouring columns in one cycle. Their data comes from an internal color register, and the DQ pins act as per-column, per-byte select bits rather than as data.

The array is split into eight column lanes, one per column position inside an aligned block. A block write can then reach all eight words in one clock, and each lane stays a plain single-write-port memory. Write-per-bit enable is latched per bank at activate time. A minimum spacing between accepted block writes is enforced in clocks. A registered read port lets the surrounding logic or a bench inspect the stored words.

Top module: `gram_blkwr`

## Requirements
- R1: While `rst` is high at a clock edge, every bank becomes idle, the mask and color registers become zero and the spacing timer clears. After that edge `err_idle`, `bw_viol` and `rd_data` are 0. Memory contents are kept across reset.
- R2: Command code 3 is the register load. With `dsf`=0 it copies `dq` into the write-per-bit mask register. With `dsf`=1 it copies `dq` into the color register. It never changes memory.
- R3: Command code 1 is activate. It opens bank `bank` at row `row` and sets that bank's write-per-bit enable to `dsf`. Both settings hold until the same bank is activated again.
- R4: Command code 2 with `dsf`=0 is a normal write. It stores `dq` at column `col` of the open row of `bank`. For each byte b with `dqm[b]`=1, that byte keeps its old value.
- R5: When the target bank's write-per-bit enable is set, only bits whose mask register bit is 1 can change. When the enable is clear, the mask register has no effect.
- R6: Command code 2 with `dsf`=1 is a block write. It targets the eight columns whose address equals `col` with its three low bits forced to 0. It writes color register data. Bit `dq[8*b+i]`=1 selects column i of the block for byte b.
- R7: During a block write, `dqm[b]`=1 keeps byte b unchanged in all eight columns of the block.
- R8: The write-per-bit mask applies to block writes exactly as it does to normal writes.
- R9: A block write is accepted only if at least `BWC` clocks separate it from the last accepted block write. A block write issued earlier changes nothing and raises `bw_viol` for one cycle after the command. Rejected block writes and normal writes do not restart the timer, and normal writes are never blocked.
- R10: A write to a bank that has not been activated since reset changes nothing and raises `err_idle` for one cycle after the command. A block write to such a bank does not raise `bw_viol`.
- R11: One cycle after a cycle with `rd_en`=1, `rd_data` holds the word at (`rd_bank`, `rd_row`, `rd_col`). It keeps that value until the next read.
- R12: `err_idle` and `bw_viol` are one-cycle pulses that follow only write commands, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command: 0 none, 1 activate, 2 write, 3 register load |
| dsf | input | 1 | Special-function strobe qualifying the command |
| bank | input | $clog2(NBANK) | Target bank |
| row | input | ROW_W | Row to open on activate |
| col | input | COL_W | Column for writes |
| dq | input | DW | Write data, register load data or block column selects |
| dqm | input | DW/8 | Per-byte write mask, 1 keeps the byte |
| rd_en | input | 1 | Read request |
| rd_bank | input | $clog2(NBANK) | Read bank |
| rd_row | input | ROW_W | Read row |
| rd_col | input | COL_W | Read column |
| rd_data | output | DW | Registered read data |
| err_idle | output | 1 | Pulse: write to a bank that is not open |
| bw_viol | output | 1 | Pulse: block write rejected for spacing |

## Verification
The bench aims at the mask combination. A byte select bit, a data mask bit and a write-per-bit bit all have to agree before a bit changes, and a design that ORs any pair would spill the color into deselected columns or masked bytes. The low column bits of a block write are set to nonzero values, so a design that fails to align the block writes the wrong eight words. The spacing rule is probed with a rejected write, a normal write inside the window and a block write on the exact boundary. A design that restarts the timer on rejection, or counts off by one, either rejects the boundary write or lets the early one through. Re-activating a bank with the opposite strobe, and writing after a second reset without activating, expose designs that keep stale per-bank state or that write into idle banks.

// File: rtl/gram_pkg.sv
package gram_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_WR   = 2'd2,
    CMD_LOAD = 2'd3
  } gcmd_e;

  localparam int BLK_COLS = 8;
  localparam int BYTE_W   = 8;
endpackage

// File: rtl/gram_bank_ctl.sv
module gram_bank_ctl #(
  parameter int NBANK = 4,
  parameter int ROW_W = 2,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_en,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [ROW_W-1:0]  act_row,
  input  logic              act_wpb,
  input  logic [BANK_W-1:0] q_bank,
  output logic              q_open,
  output logic [ROW_W-1:0]  q_row,
  output logic              q_wpb
);
  logic [NBANK-1:0]            open_r;
  logic [NBANK-1:0]            wpb_r;
  logic [NBANK-1:0][ROW_W-1:0] row_r;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        open_r[g] <= 1'b0;
        wpb_r[g]  <= 1'b0;
        row_r[g]  <= '0;
      end else if (act_en && act_bank == BANK_W'(g)) begin
        open_r[g] <= 1'b1;
        wpb_r[g]  <= act_wpb;
        row_r[g]  <= act_row;
      end
    end
  end

  assign q_open = open_r[q_bank];
  assign q_row  = row_r[q_bank];
  assign q_wpb  = wpb_r[q_bank];
endmodule

// File: rtl/gram_mask_gen.sv
module gram_mask_gen
  import gram_pkg::*;
#(
  parameter int DW = 16,
  localparam int NBYTE = DW / BYTE_W
) (
  input  logic                         commit,
  input  logic                         blk,
  input  logic [2:0]                   col_lo,
  input  logic [DW-1:0]                dq,
  input  logic [NBYTE-1:0]             dqm,
  input  logic                         wpb_on,
  input  logic [DW-1:0]                wpb_mask,
  input  logic [DW-1:0]                color,
  output logic [BLK_COLS-1:0][DW-1:0]  bit_en,
  output logic [DW-1:0]                wdata
);
  logic [DW-1:0] wpb_bits;

  always_comb begin
    wpb_bits = wpb_on ? wpb_mask : '1;
    wdata    = blk ? color : dq;
    for (int l = 0; l < BLK_COLS; l++) begin
      for (int b = 0; b < NBYTE; b++) begin
        if (commit && !dqm[b] &&
            (blk ? dq[b*BYTE_W + l] : (col_lo == 3'(l))))
          bit_en[l][b*BYTE_W +: BYTE_W] = wpb_bits[b*BYTE_W +: BYTE_W];
        else
          bit_en[l][b*BYTE_W +: BYTE_W] = '0;
      end
    end
  end
endmodule

// File: rtl/gram_lane_ram.sv
module gram_lane_ram #(
  parameter int DW = 16,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wbits,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (|wbits)
      mem[waddr] <= (mem[waddr] & ~wbits) | (wdata & wbits);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (re)
      rdata <= mem[raddr];
  end
endmodule

// File: rtl/gram_blkwr.sv
module gram_blkwr
  import gram_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int ROW_W = 2,
  parameter int COL_W = 5,
  parameter int DW    = 16,
  parameter int BWC   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               cmd,
  input  logic                     dsf,
  input  logic [$clog2(NBANK)-1:0] bank,
  input  logic [ROW_W-1:0]         row,
  input  logic [COL_W-1:0]         col,
  input  logic [DW-1:0]            dq,
  input  logic [DW/8-1:0]          dqm,
  input  logic                     rd_en,
  input  logic [$clog2(NBANK)-1:0] rd_bank,
  input  logic [ROW_W-1:0]         rd_row,
  input  logic [COL_W-1:0]         rd_col,
  output logic [DW-1:0]            rd_data,
  output logic                     err_idle,
  output logic                     bw_viol
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int NBYTE  = DW / BYTE_W;
  localparam int LANE_W = $clog2(BLK_COLS);
  localparam int AW     = BANK_W + ROW_W + COL_W - LANE_W;
  localparam int CNT_W  = $clog2(BWC + 1);

  gcmd_e cmd_e;
  logic  is_act, is_wr, is_load;
  logic  q_open, q_wpb;
  logic [ROW_W-1:0] q_row;

  logic [DW-1:0]    mask_r, color_r;
  logic [CNT_W-1:0] bw_cnt;
  logic             wr_ok, blk_try, blk_ok, norm_ok, commit;

  logic [BLK_COLS-1:0][DW-1:0] bit_en;
  logic [DW-1:0]               wdata;
  logic [BLK_COLS-1:0][DW-1:0] lane_q;
  logic [LANE_W-1:0]           rd_lane_q;
  logic [AW-1:0]               waddr, raddr;

  assign cmd_e   = gcmd_e'(cmd);
  assign is_act  = (cmd_e == CMD_ACT);
  assign is_wr   = (cmd_e == CMD_WR);
  assign is_load = (cmd_e == CMD_LOAD);

  gram_bank_ctl #(.NBANK(NBANK), .ROW_W(ROW_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .act_en   (is_act),
    .act_bank (bank),
    .act_row  (row),
    .act_wpb  (dsf),
    .q_bank   (bank),
    .q_open   (q_open),
    .q_row    (q_row),
    .q_wpb    (q_wpb)
  );

  assign wr_ok   = is_wr && q_open;
  assign blk_try = wr_ok && dsf;
  assign blk_ok  = blk_try && (bw_cnt == '0);
  assign norm_ok = wr_ok && !dsf;
  assign commit  = blk_ok || norm_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_r  <= '0;
      color_r <= '0;
    end else if (is_load) begin
      if (dsf) color_r <= dq;
      else     mask_r  <= dq;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bw_cnt <= '0;
    else if (blk_ok)
      bw_cnt <= CNT_W'(BWC - 1);
    else if (bw_cnt != '0)
      bw_cnt <= bw_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_idle <= 1'b0;
      bw_viol  <= 1'b0;
    end else begin
      err_idle <= is_wr && !q_open;
      bw_viol  <= blk_try && (bw_cnt != '0);
    end
  end

  gram_mask_gen #(.DW(DW)) u_mask (
    .commit   (commit),
    .blk      (dsf),
    .col_lo   (col[LANE_W-1:0]),
    .dq       (dq),
    .dqm      (dqm),
    .wpb_on   (q_wpb),
    .wpb_mask (mask_r),
    .color    (color_r),
    .bit_en   (bit_en),
    .wdata    (wdata)
  );

  assign waddr = {bank, q_row, col[COL_W-1:LANE_W]};
  assign raddr = {rd_bank, rd_row, rd_col[COL_W-1:LANE_W]};

  for (genvar l = 0; l < BLK_COLS; l++) begin : g_lane
    gram_lane_ram #(.DW(DW), .AW(AW)) u_ram (
      .clk   (clk),
      .rst   (rst),
      .waddr (waddr),
      .wbits (bit_en[l]),
      .wdata (wdata),
      .re    (rd_en),
      .raddr (raddr),
      .rdata (lane_q[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_lane_q <= '0;
    else if (rd_en)
      rd_lane_q <= rd_col[LANE_W-1:0];
  end

  assign rd_data = lane_q[rd_lane_q];

  logic unused_ok;
  assign unused_ok = ^{NBYTE};
endmodule

// File: rtl/gram_blkwr_chk.sv
module gram_blkwr_chk #(
  parameter int NBANK = 4,
  parameter int DW    = 16,
  parameter int BWC   = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic [1:0]               cmd,
  input logic                     dsf,
  input logic [$clog2(NBANK)-1:0] bank,
  input logic                     rd_en,
  input logic [DW-1:0]            rd_data,
  input logic                     err_idle,
  input logic                     bw_viol
);
  localparam int GAP_W = $clog2(BWC + 1) + 1;

  logic [NBANK-1:0] seen;
  logic [GAP_W-1:0] gap;
  logic             wr_c, blk_c, seen_c, acc_c;

  assign wr_c   = (cmd == 2'd2);
  assign blk_c  = wr_c && dsf;
  assign seen_c = seen[bank];
  assign acc_c  = blk_c && seen_c && (gap >= GAP_W'(BWC));

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
      gap  <= GAP_W'(BWC);
    end else begin
      if (cmd == 2'd1) seen[bank] <= 1'b1;
      if (acc_c)
        gap <= GAP_W'(1);
      else if (gap < GAP_W'(BWC))
        gap <= gap + 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!err_idle && !bw_viol && rd_data == '0));

  p_idle_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_c && !seen_c) |=> err_idle);

  p_open_noflag_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_c && seen_c) |=> !err_idle);

  p_early_block_r9: assert property (@(posedge clk) disable iff (rst)
    (blk_c && seen_c && gap < GAP_W'(BWC)) |=> bw_viol);

  p_spaced_block_r9: assert property (@(posedge clk) disable iff (rst)
    acc_c |=> !bw_viol);

  p_flag_source_r12: assert property (@(posedge clk) disable iff (rst)
    (err_idle || bw_viol) |-> $past(wr_c));

  p_flag_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(err_idle && bw_viol));

  p_read_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rd_data));
endmodule

bind gram_blkwr gram_blkwr_chk #(.NBANK(NBANK), .DW(DW), .BWC(BWC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd      (cmd),
  .dsf      (dsf),
  .bank     (bank),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .err_idle (err_idle),
  .bw_viol  (bw_viol)
);

// File: tb/sim_gram_blkwr.sv
`timescale 1ns/1ps
module sim_gram_blkwr;
  localparam int NB  = 4;
  localparam int RW  = 2;
  localparam int CW  = 5;
  localparam int DW  = 16;
  localparam int BWC = 4;
  localparam int NR  = 1 << RW;
  localparam int NC  = 1 << CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cmd = 2'd0;
  logic          dsf = 1'b0;
  logic [1:0]    bank = '0;
  logic [RW-1:0] row = '0;
  logic [CW-1:0] col = '0;
  logic [DW-1:0] dq = '0;
  logic [1:0]    dqm = '0;
  logic          rd_en = 1'b0;
  logic [1:0]    rd_bank = '0;
  logic [RW-1:0] rd_row = '0;
  logic [CW-1:0] rd_col = '0;
  logic [DW-1:0] rd_data;
  logic          err_idle, bw_viol;

  always #2 clk = ~clk;

  gram_blkwr #(.NBANK(NB), .ROW_W(RW), .COL_W(CW), .DW(DW), .BWC(BWC)) u0 (
    .clk(clk), .rst(rst), .cmd(cmd), .dsf(dsf), .bank(bank), .row(row),
    .col(col), .dq(dq), .dqm(dqm), .rd_en(rd_en), .rd_bank(rd_bank),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
    .err_idle(err_idle), .bw_viol(bw_viol)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  logic [DW-1:0] mdl [NB][NR][NC];
  bit            opn [NB];
  int            orow [NB];
  bit            wpbm [NB];
  logic [DW-1:0] mmask, mcolor;
  int            last_bw;
  logic [DW-1:0] last_rd;

  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic          pend = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) pend <= rd_en;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R11 actual=%h expected=<none>", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      opn[b] = 0; wpbm[b] = 0; orow[b] = 0;
    end
    mmask = '0; mcolor = '0; last_bw = -1000;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R1 err_idle", {15'd0, err_idle}, 16'd0);
    check("R1 bw_viol", {15'd0, bw_viol}, 16'd0);
    check("R1 rd_data", rd_data, 16'd0);
  endtask

  task automatic apply_word(input int b, input int c, input logic [DW-1:0] d,
                            input logic [DW-1:0] en);
    mdl[b][orow[b]][c] = (mdl[b][orow[b]][c] & ~en) | (d & en);
  endtask

  task automatic do_cmd(input logic [1:0] c, input logic d, input int b,
                        input int r, input int cl, input logic [DW-1:0] q,
                        input logic [1:0] m, input string tag);
    logic ee, ev;
    logic [DW-1:0] wm, en;
    ee = 0; ev = 0;
    wm = wpbm[b] ? mmask : '1;
    case (c)
      2'd1: begin opn[b] = 1; orow[b] = r; wpbm[b] = d; end
      2'd3: begin if (d) mcolor = q; else mmask = q; end
      2'd2: begin
        if (!opn[b]) ee = 1;
        else if (d) begin
          if (cyc - last_bw < BWC) ev = 1;
          else begin
            last_bw = cyc;
            for (int i = 0; i < 8; i++) begin
              en = '0;
              for (int by = 0; by < 2; by++)
                if (q[8*by+i] && !m[by]) en[8*by +: 8] = 8'hFF;
              apply_word(b, (cl & ~7) + i, mcolor, en & wm);
            end
          end
        end else begin
          en = '0;
          for (int by = 0; by < 2; by++)
            if (!m[by]) en[8*by +: 8] = 8'hFF;
          apply_word(b, cl, q, en & wm);
        end
      end
      default: ;
    endcase
    cmd = c; dsf = d; bank = 2'(b); row = RW'(r); col = CW'(cl); dq = q; dqm = m;
    @(negedge clk);
    check({tag, " err_idle"}, {15'd0, err_idle}, {15'd0, ee});
    check({tag, " bw_viol"}, {15'd0, bw_viol}, {15'd0, ev});
    cmd = 2'd0; dsf = 0; dq = '0; dqm = '0;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R12 err_idle quiet", {15'd0, err_idle}, 16'd0);
      check("R12 bw_viol quiet", {15'd0, bw_viol}, 16'd0);
    end
  endtask

  task automatic rd(input int b, input int r, input int c, input string tag);
    last_rd = mdl[b][r][c];
    exp_q.push_back(last_rd);
    tag_q.push_back(tag);
    rd_en = 1; rd_bank = 2'(b); rd_row = RW'(r); rd_col = CW'(c);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++)
        for (int c = 0; c < NC; c++) mdl[b][r][c] = 'x;
    @(negedge clk);
    do_reset();

    // R2 color zero, clear row 1 of every bank with full block writes
    do_cmd(2'd3, 1, 0, 0, 0, 16'h0000, 2'b00, "R2 load color");
    for (int b = 0; b < NB; b++) do_cmd(2'd1, 0, b, 1, 0, 0, 2'b00, "R3 act");
    for (int b = 0; b < NB; b++) begin
      do_cmd(2'd2, 1, b, 0, 0, 16'hFFFF, 2'b00, "R6 init");
      nop(BWC - 1);
      do_cmd(2'd2, 1, b, 0, 8, 16'hFFFF, 2'b00, "R6 init");
      nop(BWC - 1);
    end
    rd(2, 1, 5, "R6 init read");

    // R4 normal write and byte mask
    do_cmd(2'd2, 0, 0, 0, 3, 16'hA5C3, 2'b00, "R4 write");
    rd(0, 1, 3, "R4 full word");
    do_cmd(2'd2, 0, 0, 0, 3, 16'h1234, 2'b01, "R4 dqm byte0");
    rd(0, 1, 3, "R4 byte0 kept");
    rd(0, 1, 2, "R4 neighbour");

    // R5 write-per-bit on bank 1 only
    do_cmd(2'd3, 0, 0, 0, 0, 16'h0F0F, 2'b00, "R2 load mask");
    do_cmd(2'd1, 1, 1, 1, 0, 0, 2'b00, "R3 act wpb");
    do_cmd(2'd2, 0, 1, 0, 2, 16'hFFFF, 2'b00, "R5 wpb write");
    rd(1, 1, 2, "R5 masked bits");
    do_cmd(2'd2, 0, 0, 0, 4, 16'hFFFF, 2'b00, "R5 wpb off");
    rd(0, 1, 4, "R5 unmasked bank");

    // R6 block write, unaligned column, mixed selects
    do_cmd(2'd3, 1, 0, 0, 0, 16'h1234, 2'b00, "R2 color");
    do_cmd(2'd2, 1, 2, 0, 13, 16'h0FA5, 2'b00, "R6 block");
    for (int i = 8; i < 16; i++) rd(2, 1, i, "R6 block col");
    rd(2, 1, 7, "R6 outside block");

    // R7 byte mask over whole block
    do_cmd(2'd3, 1, 0, 0, 0, 16'hBEEF, 2'b00, "R2 color");
    do_cmd(2'd2, 1, 3, 0, 1, 16'hFFFF, 2'b10, "R7 block dqm");
    for (int i = 0; i < 8; i++) rd(3, 1, i, "R7 block col");

    // R8 write-per-bit on block write
    do_cmd(2'd2, 1, 1, 0, 8, 16'hF00F, 2'b00, "R8 block wpb");
    for (int i = 8; i < 16; i++) rd(1, 1, i, "R8 block col");

    // R9 spacing
    nop(BWC);
    do_cmd(2'd3, 1, 0, 0, 0, 16'hC3C3, 2'b00, "R2 color");
    do_cmd(2'd2, 1, 3, 0, 8, 16'hFFFF, 2'b00, "R9 first");
    do_cmd(2'd3, 0, 0, 0, 0, 16'hFFFF, 2'b00, "R2 mask");
    do_cmd(2'd2, 1, 2, 0, 0, 16'hFFFF, 2'b00, "R9 early");
    do_cmd(2'd2, 0, 3, 0, 20, 16'h5A5A, 2'b00, "R9 normal in window");
    do_cmd(2'd2, 1, 0, 0, 8, 16'hFFFF, 2'b00, "R9 boundary");
    nop(1);
    rd(2, 1, 0, "R9 rejected unchanged");
    rd(3, 1, 20, "R9 normal written");
    rd(0, 1, 9, "R9 boundary written");

    // R3 re-activate clears write-per-bit; row select
    do_cmd(2'd3, 0, 0, 0, 0, 16'h00FF, 2'b00, "R2 mask");
    do_cmd(2'd1, 0, 1, 1, 0, 0, 2'b00, "R3 react");
    do_cmd(2'd2, 0, 1, 0, 3, 16'h7777, 2'b00, "R3 wpb cleared");
    rd(1, 1, 3, "R3 full write");
    do_cmd(2'd1, 0, 0, 2, 0, 0, 2'b00, "R3 row2");
    do_cmd(2'd2, 0, 0, 0, 3, 16'h9ABC, 2'b00, "R3 row2 write");
    rd(0, 2, 3, "R3 row2 word");
    rd(0, 1, 3, "R3 row1 untouched");

    // R11 hold
    nop(3);
    check("R11 hold", rd_data, last_rd);

    // R10 idle bank after reset, memory kept
    do_reset();
    do_cmd(2'd2, 0, 0, 0, 3, 16'h0000, 2'b00, "R10 idle write");
    nop(1);
    do_cmd(2'd2, 1, 2, 0, 8, 16'hFFFF, 2'b00, "R10 idle block");
    nop(1);
    do_cmd(2'd1, 0, 0, 1, 0, 0, 2'b00, "R3 act");
    do_cmd(2'd1, 0, 2, 1, 0, 0, 2'b00, "R3 act");
    rd(0, 1, 3, "R10 kept");
    rd(2, 1, 9, "R10 block kept");
    nop(3);

    done = 1;
    finish_run();
  end
endmodule